// File: doc/BRIEF.md
# ADC Sample FIFO with Fill-Level Interrupt

This block sits between an analog-to-digital converter and the host. Each converted sample comes in with the number of the channel that produced it. The block stores the sample in a 64-entry first-in first-out buffer. The host finds out how many words are waiting by reading an occupancy register. It then reads that many words, one at a time, from a data register. Each read of the data register removes the oldest entry.

A programmable fill threshold (1 to 256) produces a level event at the moment a stored sample brings the occupancy up to the threshold. A control bit sends this event to one of two places:
- a one-cycle trigger pulse for other hardware, or
- the level bit of an interrupt request register.

That register also records two error conditions: a sample that arrives while the buffer is full, and a data read while the buffer is empty. Software can set and clear the request bits, mask them, and read the masked view. The level bit can be cleared automatically by a data read, or left for software to clear.

A two-state controller gates the buffer:
- ST_OFF: storage is inert, and the pointers, the count and every request bit are held at zero.
- ST_RUN: samples and reads take effect.

The transition ST_OFF→ST_RUN happens when the converter enable input is high and the use bit in the control register is set. ST_RUN→ST_OFF happens as soon as either one drops.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset, control reads 0, threshold reads 1, occupancy reads 0, request and mask read 0, and both `irq_o` and `trig_o` are low.
- R2: Samples are stored only in ST_RUN, that is, only one cycle after `conv_en_i` and control bit 0 (use) are both high. While either is low, incoming samples leave the occupancy at 0.
- R3: Entries are read back in arrival order. Occupancy (register address 2) rises by one per accepted sample and falls by one per data read, never beyond 64.
- R4: A data read (address 3) returns the sample in bits 15:0. Bits 19:16 carry the channel when control bit 1 (tag) is set, and read 0 when it is clear. All other bits are 0.
- R5: With control bit 3 clear, a sample that brings the occupancy up to the threshold (address 1) sets request bit 0. A threshold above 64 never sets it.
- R6: With control bit 3 set, the level event instead drives `trig_o` high for exactly the one cycle after the accepting edge, and request bit 0 stays clear.
- R7: With control bit 2 set, each accepted data read clears request bit 0. With it clear, bit 0 stays set until 1 is written to bit 0 of the request register.
- R8: A sample that arrives while the occupancy is 64, with no data read in the same cycle, is dropped. The occupancy stays 64 and request bit 1 is set.
- R9: A data read while the buffer is empty returns 0, leaves the occupancy at 0, and sets request bit 2.
- R10: Writing 1s to the set register (address 5) sets those request bits. Writing 1s to the request register (address 4) clears them.
- R11: The masked register (address 7) reads request AND mask (address 6), and `irq_o` is high exactly when that value is nonzero.
- R12: Leaving ST_RUN clears the occupancy, the pointers and all request bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_en_i | input | 1 | Converter enable; the buffer runs only while high |
| smp_valid_i | input | 1 | A converted sample is presented this cycle |
| smp_value_i | input | 16 | Sample value |
| smp_chan_i | input | 4 | Channel that produced the sample |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; pops an entry at the data address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the same cycle as the address |
| irq_o | output | 1 | Interrupt line, OR of the masked request bits |
| trig_o | output | 1 | One-cycle level trigger pulse |

## Verification
The assertions check these properties on every cycle:
- the occupancy stays bounded and changes by at most one per cycle;
- a dropped sample leaves the buffer at 64 with the overflow bit set;
- an empty read raises the underflow bit;
- the interrupt line stays quiet under a zero mask;
- trigger pulses last one cycle and appear only when routed;
- everything is cleared after leaving ST_RUN.

Data order, channel tagging, and the exact sample at which the level event fires for each threshold can only be shown by the bench's scenarios. The same holds for the automatic and manual clear choices and for the full grid of set and mask patterns.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int IRQ_N   = 3;
    localparam int IRQ_LVL = 0;
    localparam int IRQ_OVF = 1;
    localparam int IRQ_UDF = 2;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_LEVEL  = 3'd1,
        RA_COUNT  = 3'd2,
        RA_DATA   = 3'd3,
        RA_REQ    = 3'd4,
        RA_SET    = 3'd5,
        RA_MASK   = 3'd6,
        RA_MASKED = 3'd7
    } reg_addr_e;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    typedef struct packed {
        logic route_trig;
        logic auto_clr;
        logic tag_en;
        logic use_fifo;
    } ctrl_t;

endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DEPTH = 64,
    parameter int W     = 20,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[wp_q] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            unique case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata_o = mem_q[rp_q];
    assign count_o = cnt_q;
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/afifo_irq.sv
module afifo_irq
    import afifo_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             lvl_evt_i,
    input  logic             route_i,
    input  logic             ovf_i,
    input  logic             udf_i,
    input  logic             pop_i,
    input  logic             auto_clr_i,
    input  logic [IRQ_N-1:0] sw_set_i,
    input  logic [IRQ_N-1:0] sw_clr_i,
    output logic [IRQ_N-1:0] req_o,
    output logic             trig_o
);

    logic [IRQ_N-1:0] req_q, hw_set, auto_mask;

    always_comb begin
        hw_set            = '0;
        hw_set[IRQ_LVL]   = lvl_evt_i & ~route_i;
        hw_set[IRQ_OVF]   = ovf_i;
        hw_set[IRQ_UDF]   = udf_i;
        auto_mask          = '0;
        auto_mask[IRQ_LVL] = pop_i & auto_clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q  <= '0;
            trig_o <= 1'b0;
        end else if (clr_i) begin
            req_q  <= '0;
            trig_o <= 1'b0;
        end else begin
            req_q  <= (req_q & ~sw_clr_i & ~auto_mask) | sw_set_i | hw_set;
            trig_o <= lvl_evt_i & route_i;
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
    import afifo_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int SMP_W   = 16,
    parameter int CH_W    = 4,
    parameter int LEVEL_W = 9,
    parameter int DATA_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              conv_en_i,
    input  logic              smp_valid_i,
    input  logic [SMP_W-1:0]  smp_value_i,
    input  logic [CH_W-1:0]   smp_chan_i,
    input  logic [2:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              trig_o
);

    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int ENTRY_W = SMP_W + CH_W;

    run_state_e       state_q, state_d;
    ctrl_t            ctrl_q;
    logic [LEVEL_W-1:0] level_q;
    logic [IRQ_N-1:0] mask_q, req, sw_set, sw_clr;
    logic             run, clr, route_trig;
    logic             pop_req, push_acc, pop_acc, ovf, udf, lvl_evt;
    logic [ENTRY_W-1:0] head;
    logic [CNT_W-1:0] count;
    logic             full, empty;
    reg_addr_e        addr;

    assign addr       = reg_addr_e'(reg_addr_i);
    assign route_trig = ctrl_q.route_trig;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (conv_en_i && ctrl_q.use_fifo)    state_d = ST_RUN;
            ST_RUN: if (!(conv_en_i && ctrl_q.use_fifo)) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        run = 1'b0;
        clr = 1'b1;
        unique case (state_q)
            ST_OFF: begin run = 1'b0; clr = 1'b1; end
            ST_RUN: begin run = 1'b1; clr = 1'b0; end
            default: begin run = 1'b0; clr = 1'b1; end
        endcase
    end

    assign pop_req  = reg_rd_i && (addr == RA_DATA);
    assign pop_acc  = run && pop_req && !empty;
    assign push_acc = run && smp_valid_i && (!full || pop_acc);
    assign ovf      = run && smp_valid_i && full && !pop_acc;
    assign udf      = run && pop_req && empty;
    assign lvl_evt  = push_acc && !pop_acc &&
                      ((LEVEL_W'(count) + 1'b1) == level_q);

    // configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q  <= '0;
            level_q <= LEVEL_W'(1);
            mask_q  <= '0;
        end else if (reg_wr_i) begin
            unique case (addr)
                RA_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata_i[3:0]);
                RA_LEVEL: level_q <= reg_wdata_i[LEVEL_W-1:0];
                RA_MASK:  mask_q  <= reg_wdata_i[IRQ_N-1:0];
                default:  ;
            endcase
        end
    end

    assign sw_set = (reg_wr_i && addr == RA_SET) ? reg_wdata_i[IRQ_N-1:0] : '0;
    assign sw_clr = (reg_wr_i && addr == RA_REQ) ? reg_wdata_i[IRQ_N-1:0] : '0;

    afifo_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr),
        .push_i  (push_acc),
        .pop_i   (pop_acc),
        .wdata_i ({smp_chan_i, smp_value_i}),
        .rdata_o (head),
        .count_o (count),
        .full_o  (full),
        .empty_o (empty)
    );

    afifo_irq u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (clr),
        .lvl_evt_i  (lvl_evt),
        .route_i    (ctrl_q.route_trig),
        .ovf_i      (ovf),
        .udf_i      (udf),
        .pop_i      (pop_acc),
        .auto_clr_i (ctrl_q.auto_clr),
        .sw_set_i   (sw_set),
        .sw_clr_i   (sw_clr),
        .req_o      (req),
        .trig_o     (trig_o)
    );

    assign irq_o = |(req & mask_q);

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        unique case (addr)
            RA_CTRL:   reg_rdata_o = DATA_W'(ctrl_q);
            RA_LEVEL:  reg_rdata_o = DATA_W'(level_q);
            RA_COUNT:  reg_rdata_o = DATA_W'(count);
            RA_DATA:   if (run && !empty)
                           reg_rdata_o = DATA_W'({ctrl_q.tag_en ? head[ENTRY_W-1:SMP_W]
                                                                : {CH_W{1'b0}},
                                                  head[SMP_W-1:0]});
            RA_REQ:    reg_rdata_o = DATA_W'(req);
            RA_SET:    reg_rdata_o = DATA_W'(req);
            RA_MASK:   reg_rdata_o = DATA_W'(mask_q);
            RA_MASKED: reg_rdata_o = DATA_W'(req & mask_q);
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk
    import afifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run,
    input logic             smp_valid,
    input logic             pop_req,
    input logic             full,
    input logic             empty,
    input logic [CW-1:0]    count,
    input logic [IRQ_N-1:0] req,
    input logic [IRQ_N-1:0] mask,
    input logic             irq,
    input logic             trig,
    input logic             route
);

    AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count <= CW'(DEPTH)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |=> (count == $past(count) || count == $past(count) + 1'b1 ||
                 count + 1'b1 == $past(count))); // R3

    AST_OVF_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && smp_valid && full && !pop_req) |=>
            (count == CW'(DEPTH) && req[IRQ_OVF])); // R8

    AST_UDF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && pop_req && empty) |=> req[IRQ_UDF]); // R9

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask == '0) |-> !irq); // R11

    AST_TRIG_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig |-> $past(route)); // R6

    AST_TRIG_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig |=> !trig); // R6

    AST_OFF_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> (count == '0 && req == '0)); // R12

endmodule

bind adc_sample_fifo afifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run       (run),
    .smp_valid (smp_valid_i),
    .pop_req   (pop_req),
    .full      (full),
    .empty     (empty),
    .count     (count),
    .req       (req),
    .mask      (mask_q),
    .irq       (irq_o),
    .trig      (trig_o),
    .route     (route_trig)
);

// File: tb/sim_adc_sample_fifo.sv
module sim_adc_sample_fifo;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CTRL = 3'd0, A_LEVEL = 3'd1, A_COUNT = 3'd2,
                           A_DATA = 3'd3, A_REQ = 3'd4, A_SET = 3'd5,
                           A_MASK = 3'd6, A_MASKED = 3'd7;
    localparam logic [31:0] C_USE = 32'h1, C_TAG = 32'h2, C_AUTO = 32'h4,
                            C_ROUTE = 32'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_value = '0;
    logic [3:0]  smp_chan = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, trig;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_fifo u0 (
        .clk_i(clk), .rst_ni(rst_n), .conv_en_i(conv_en),
        .smp_valid_i(smp_valid), .smp_value_i(smp_value), .smp_chan_i(smp_chan),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .irq_o(irq), .trig_o(trig)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic push(input logic [3:0] ch, input logic [15:0] v, output logic tr);
        @(negedge clk); smp_chan = ch; smp_value = v; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0; tr = trig;
    endtask

    task automatic restart(input logic [31:0] ctrl, input logic [31:0] lvl);
        conv_en = 1'b0;
        wr(A_CTRL, 32'h0);
        repeat (2) @(negedge clk);
        wr(A_LEVEL, lvl);
        wr(A_MASK, 32'h0);
        wr(A_CTRL, ctrl | C_USE);
        conv_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] val_of(input int k);
        return 16'(k * 16'h0123 + 16'h0A05);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic tr;
        int lvls[9] = '{1, 2, 3, 17, 63, 64, 65, 200, 256};
        int tlv[3]  = '{1, 5, 64};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
        rd(A_LEVEL, d); chk("R1 level", d, 1);
        rd(A_COUNT, d); chk("R1 count", d, 0);
        rd(A_REQ, d);   chk("R1 req", d, 0);
        rd(A_MASK, d);  chk("R1 mask", d, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 trig", 32'(trig), 0);

        // R2 gating by enable and use bit
        conv_en = 1'b1;
        for (int k = 0; k < 3; k++) push(4'(k), 16'(k), tr);
        rd(A_COUNT, d); chk("R2 use clear", d, 0);
        conv_en = 1'b0;
        wr(A_CTRL, C_USE);
        for (int k = 0; k < 3; k++) push(4'(k), 16'(k), tr);
        rd(A_COUNT, d); chk("R2 conv off", d, 0);

        // R5 / R3 / R8 threshold sweep with interrupt routing
        foreach (lvls[i]) begin
            restart(32'h0, 32'(lvls[i]));
            for (int k = 1; k <= 64; k++) begin
                push(4'(k), val_of(k), tr);
                rd(A_COUNT, d); chk("R3 count", d, 32'(k));
                rd(A_REQ, d);   chk("R5 level bit", d & 32'h1, (k >= lvls[i]) ? 1 : 0);
            end
            push(4'h0, 16'hFFFF, tr);
            rd(A_COUNT, d); chk("R8 count full", d, 64);
            rd(A_REQ, d);   chk("R8 ovf bit", (d >> 1) & 32'h1, 1);
        end

        // R6 trigger routing
        foreach (tlv[i]) begin
            int pulses;
            pulses = 0;
            restart(C_ROUTE, 32'(tlv[i]));
            for (int k = 1; k <= 64; k++) begin
                push(4'(k), val_of(k), tr);
                chk("R6 trig pulse", 32'(tr), (k == tlv[i]) ? 1 : 0);
                if (tr) pulses++;
                @(negedge clk);
                chk("R6 trig one cycle", 32'(trig), 0);
            end
            chk("R6 pulse count", 32'(pulses), 1);
            rd(A_REQ, d); chk("R6 level bit clear", d & 32'h1, 0);
        end

        // R3 / R4 order and tagging, R9 underflow
        for (int tg = 0; tg < 2; tg++) begin
            restart(tg ? C_TAG : 32'h0, 32'd256);
            for (int k = 0; k < 64; k++) push(4'(k * 7), val_of(k), tr);
            for (int k = 0; k < 64; k++) begin
                rd(A_DATA, d);
                chk("R4 data word", d,
                    {12'h0, tg ? 4'(k * 7) : 4'h0, val_of(k)});
            end
            rd(A_COUNT, d); chk("R3 drained", d, 0);
            rd(A_DATA, d);  chk("R9 empty read", d, 0);
            rd(A_COUNT, d); chk("R9 count", d, 0);
            rd(A_REQ, d);   chk("R9 udf bit", (d >> 2) & 32'h1, 1);
        end

        // R7 automatic clear
        restart(C_AUTO, 32'd2);
        push(4'h1, 16'h11, tr); push(4'h2, 16'h22, tr);
        rd(A_REQ, d);  chk("R7 auto set", d & 32'h1, 1);
        rd(A_DATA, d);
        rd(A_REQ, d);  chk("R7 auto cleared", d & 32'h1, 0);
        // R7 manual clear
        restart(32'h0, 32'd2);
        push(4'h1, 16'h11, tr); push(4'h2, 16'h22, tr);
        rd(A_DATA, d);
        rd(A_REQ, d);  chk("R7 manual held", d & 32'h1, 1);
        wr(A_REQ, 32'h1);
        rd(A_REQ, d);  chk("R7 manual w1c", d & 32'h1, 0);

        // R10 / R11 set, clear and mask grid
        restart(32'h0, 32'd256);
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 8; s++) begin
                wr(A_REQ, 32'h7);
                wr(A_MASK, 32'(m));
                wr(A_SET, 32'(s));
                rd(A_REQ, d);    chk("R10 set", d, 32'(s));
                rd(A_MASKED, d); chk("R11 masked", d, 32'(s & m));
                chk("R11 irq", 32'(irq), ((s & m) != 0) ? 1 : 0);
            end
        end
        wr(A_REQ, 32'h5);
        rd(A_REQ, d); chk("R10 w1c partial", d, 32'h2);

        // R12 disable clears
        restart(32'h0, 32'd256);
        for (int k = 0; k < 5; k++) push(4'(k), val_of(k), tr);
        wr(A_SET, 32'h7);
        conv_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(A_COUNT, d); chk("R12 count", d, 0);
        rd(A_REQ, d);   chk("R12 req", d, 0);
        conv_en = 1'b1;
        repeat (2) @(negedge clk);
        rd(A_COUNT, d); chk("R12 count after re-enable", d, 0);
        push(4'h3, 16'hBEEF, tr);
        wr(A_CTRL, C_USE | C_TAG);
        rd(A_DATA, d);  chk("R12 pointers reset", d, 32'h3BEEF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule